// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block decides when an SDRAM controller takes its memory into a low-power state and brings it back. There are two ways in. The first is self-refresh on request. A user raises a level request. The block lets reads and writes already in flight finish, holds the command queue, has the scheduler close all banks, and then issues the self-refresh entry command with clock-enable low. It acknowledges and stays in self-refresh until the request drops. It then raises clock-enable, waits out an exit delay, and only after that lowers the acknowledge and releases the queue. The second way in is automatic power-down. An idle counter runs while the command queue holds no reads or writes. When the counter meets a programmed limit, clock-enable drops and a power-down acknowledge rises. A new access wakes the memory, with a short fixed exit delay.

Periodic refresh strobes are latched as pending. The block requests an auto-refresh from the scheduler when no self-refresh request is waiting. A pending refresh holds off power-down entry and also wakes the memory from power-down.

States: `LP_ACTIVE` (normal traffic), `LP_REF` (auto-refresh requested), `LP_SR_DRAIN` (waiting for in-flight accesses), `LP_SR_PRE` (precharge-all requested), `LP_SR_ENTER` (one-cycle entry command, clock-enable low), `LP_SR_HOLD` (in self-refresh), `LP_SR_EXIT` (exit delay), `LP_PD` (powered down), `LP_PD_EXIT` (power-down exit delay).

Transitions:
- ACTIVE goes to SR_DRAIN on a self-refresh request. Otherwise it goes to REF if a refresh is pending. Otherwise it goes to PD when the idle limit is hit.
- REF goes to ACTIVE on the completion strobe.
- SR_DRAIN goes to SR_PRE once nothing is in flight.
- SR_PRE goes to SR_ENTER on the completion strobe.
- SR_ENTER always goes to SR_HOLD.
- SR_HOLD goes to SR_EXIT when the request drops.
- SR_EXIT goes to ACTIVE when the delay expires.
- PD goes to PD_EXIT on a queued access, a self-refresh request, or a refresh strobe or pending refresh.
- PD_EXIT goes to ACTIVE when the delay expires.

Top module: `dram_lp_seq`

## Requirements
- R1: In reset and in the first cycle after it, `cke` is 1 and `sr_ack`, `pd_ack`, `q_stall`, `cmd_pre_all`, `cmd_sr_enter` and `cmd_auto_ref` are all 0.
- R2: Take the edge that samples `sr_req` high in the active state. `q_stall` is 1 from that edge on. `cmd_pre_all` stays 0 for as long as `rw_inflight` is 1.
- R3: `cmd_pre_all` is 1 from the edge after `rw_inflight` is seen low until `cmd_done` is sampled. On that edge `cmd_sr_enter` is raised for exactly one cycle, with `cke` 0 in the same cycle.
- R4: `sr_ack` rises the cycle after the entry command. `sr_ack` stays 1 and `cke` stays 0 for as long as `sr_req` is held, with no upper bound.
- R5: On the edge that samples `sr_req` low in self-refresh, `cke` goes to 1. `sr_ack` and `q_stall` stay 1 for `SR_EXIT_CYC` cycles and then fall together.
- R6: A `refresh_due` strobe is held pending. If `sr_req` is high in the active state, the self-refresh sequence runs first, and `cmd_auto_ref` stays 0 through all of it. The pending refresh is requested on the edge after the block returns to the active state. `cmd_auto_ref` holds until `cmd_done`.
- R7: The idle counter advances once per cycle in the active state while `q_rw_pending` is 0, and any cycle with `q_rw_pending` 1 clears it. With limit L, `pd_ack` is seen L+1 edges after the queue becomes empty.
- R8: An `idle_limit` of 0 turns off automatic power-down.
- R9: In power-down, `cke` is 0 and `pd_ack` and `q_stall` are 1. On the edge that samples `q_rw_pending` high, `cke` goes to 1. `pd_ack` and `q_stall` fall `PD_EXIT_CYC` cycles after that edge.
- R10: While a refresh is pending or being served, power-down is not entered. A `refresh_due` strobe in power-down wakes the memory, and the auto-refresh request follows the exit delay.
- R11: A `sr_req` in power-down first runs the power-down exit. It then runs the full self-refresh entry sequence from the drain step.
- R12: At most one of `cmd_pre_all`, `cmd_sr_enter` and `cmd_auto_ref` is high in any cycle. The two acknowledges are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Level request to enter and hold self-refresh |
| q_rw_pending | input | 1 | Command queue holds at least one read or write |
| rw_inflight | input | 1 | A read or write is still executing |
| refresh_due | input | 1 | One-cycle periodic refresh strobe |
| idle_limit | input | IDLE_W | Idle cycles before power-down; 0 disables |
| cmd_done | input | 1 | Scheduler strobe: requested command has been issued |
| cke | output | 1 | Memory clock-enable level |
| q_stall | output | 1 | Hold the command queue |
| sr_ack | output | 1 | Memory is in self-refresh or still leaving it |
| pd_ack | output | 1 | Memory is in power-down or still leaving it |
| cmd_pre_all | output | 1 | Request precharge-all from the scheduler |
| cmd_sr_enter | output | 1 | Request self-refresh entry from the scheduler |
| cmd_auto_ref | output | 1 | Request auto-refresh from the scheduler |

## Verification
The bench builds the block with `SR_EXIT_CYC` = 5 and `PD_EXIT_CYC` = 3, so that every exit window can be counted edge by edge within a few cycles. It keeps the full 16-bit idle limit. It sweeps that limit from 1 to 8 and checks the L+1 entry latency and the three-cycle wake for every value. It also covers limit 0 and a counter cleared partway through an idle stretch. The short exit delays make it cheap to chain the mixed cases: refresh together with a self-refresh request, refresh during power-down, and a self-refresh request during power-down.

// File: rtl/dram_lp_pkg.sv
package dram_lp_pkg;

    typedef enum logic [3:0] {
        LP_ACTIVE,
        LP_REF,
        LP_SR_DRAIN,
        LP_SR_PRE,
        LP_SR_ENTER,
        LP_SR_HOLD,
        LP_SR_EXIT,
        LP_PD,
        LP_PD_EXIT
    } lp_state_e;

endpackage

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run && cnt != limit)
            cnt <= cnt + 1'b1;
    end

    assign hit = (limit != '0) && (cnt == limit);

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0)); // R7

    AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && cnt != limit && $stable(limit)) |=> (cnt == $past(cnt) + 1'b1)); // R7

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |-> !hit); // R8

endmodule

// File: rtl/lp_delay_timer.sv
module lp_delay_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         done
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= len - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_DLY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5

    AST_DLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len > 1) |=> !done); // R9

endmodule

// File: rtl/dram_lp_seq.sv
module dram_lp_seq
    import dram_lp_pkg::*;
#(
    parameter int IDLE_W      = 16,
    parameter int SR_EXIT_CYC = 200,
    parameter int PD_EXIT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_req,
    input  logic              q_rw_pending,
    input  logic              rw_inflight,
    input  logic              refresh_due,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              cmd_done,
    output logic              cke,
    output logic              q_stall,
    output logic              sr_ack,
    output logic              pd_ack,
    output logic              cmd_pre_all,
    output logic              cmd_sr_enter,
    output logic              cmd_auto_ref
);

    localparam int MAX_DLY = (SR_EXIT_CYC > PD_EXIT_CYC) ? SR_EXIT_CYC : PD_EXIT_CYC;
    localparam int DLY_W   = $clog2(MAX_DLY + 1);
    localparam logic [DLY_W-1:0] SR_LEN = DLY_W'(SR_EXIT_CYC);
    localparam logic [DLY_W-1:0] PD_LEN = DLY_W'(PD_EXIT_CYC);

    lp_state_e        state, state_n;
    logic             ref_pend;
    logic             idle_hit;
    logic             dly_start;
    logic             dly_done;
    logic [DLY_W-1:0] dly_len;
    logic             pd_wake;
    logic             in_active;

    assign in_active = (state == LP_ACTIVE);
    assign pd_wake   = q_rw_pending || sr_req || ref_pend || refresh_due;

    lp_idle_timer #(.W(IDLE_W)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_active),
        .clear (!in_active || q_rw_pending),
        .limit (idle_limit),
        .hit   (idle_hit)
    );

    assign dly_start = ((state == LP_SR_HOLD) && !sr_req) || ((state == LP_PD) && pd_wake);
    assign dly_len   = (state == LP_PD) ? PD_LEN : SR_LEN;

    lp_delay_timer #(.W(DLY_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dly_start),
        .len   (dly_len),
        .done  (dly_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_pend <= 1'b0;
        else if (refresh_due)
            ref_pend <= 1'b1;
        else if (state == LP_REF && cmd_done)
            ref_pend <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= LP_ACTIVE;
        else
            state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            LP_ACTIVE: begin
                if (sr_req)        state_n = LP_SR_DRAIN;
                else if (ref_pend) state_n = LP_REF;
                else if (idle_hit) state_n = LP_PD;
            end
            LP_REF:      if (cmd_done)     state_n = LP_ACTIVE;
            LP_SR_DRAIN: if (!rw_inflight) state_n = LP_SR_PRE;
            LP_SR_PRE:   if (cmd_done)     state_n = LP_SR_ENTER;
            LP_SR_ENTER:                   state_n = LP_SR_HOLD;
            LP_SR_HOLD:  if (!sr_req)      state_n = LP_SR_EXIT;
            LP_SR_EXIT:  if (dly_done)     state_n = LP_ACTIVE;
            LP_PD:       if (pd_wake)      state_n = LP_PD_EXIT;
            LP_PD_EXIT:  if (dly_done)     state_n = LP_ACTIVE;
            default:                       state_n = LP_ACTIVE;
        endcase
    end

    always_comb begin
        cke          = 1'b1;
        q_stall      = 1'b1;
        sr_ack       = 1'b0;
        pd_ack       = 1'b0;
        cmd_pre_all  = 1'b0;
        cmd_sr_enter = 1'b0;
        cmd_auto_ref = 1'b0;
        unique case (state)
            LP_ACTIVE:   q_stall = 1'b0;
            LP_REF:      cmd_auto_ref = 1'b1;
            LP_SR_DRAIN: ;
            LP_SR_PRE:   cmd_pre_all = 1'b1;
            LP_SR_ENTER: begin
                cmd_sr_enter = 1'b1;
                cke          = 1'b0;
            end
            LP_SR_HOLD: begin
                sr_ack = 1'b1;
                cke    = 1'b0;
            end
            LP_SR_EXIT:  sr_ack = 1'b1;
            LP_PD: begin
                pd_ack = 1'b1;
                cke    = 1'b0;
            end
            LP_PD_EXIT:  pd_ack = 1'b1;
            default:     q_stall = 1'b0;
        endcase
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_pre_all, cmd_sr_enter, cmd_auto_ref})); // R12

    AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_ack && pd_ack)); // R12

    AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_inflight && !cmd_pre_all) |=> !cmd_pre_all); // R2

    AST_PRE_BEFORE_SRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_sr_enter) |-> $past(cmd_pre_all)); // R3

    AST_SRE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sr_enter |-> !cke); // R3

    AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_ack && !cke && sr_req) |=> (sr_ack && !cke)); // R4

    AST_SR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_ack && !cke && !sr_req) |=> (cke && sr_ack)); // R5

    AST_ACK_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_ack || pd_ack) |-> q_stall); // R5

    AST_SR_BEATS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_active && sr_req) |=> !cmd_auto_ref); // R6

    AST_PD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_ack && !cke && q_rw_pending) |=> cke); // R9

    AST_NO_PD_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend && !pd_ack) |=> !pd_ack); // R10

endmodule

// File: tb/dram_lp_seq_bench.sv
module dram_lp_seq_bench;

    localparam int IDLE_W = 16;
    localparam int SR_X   = 5;
    localparam int PD_X   = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sr_req, q_rw_pending, rw_inflight, refresh_due, cmd_done;
    logic [IDLE_W-1:0] idle_limit;
    logic              cke, q_stall, sr_ack, pd_ack, cmd_pre_all, cmd_sr_enter, cmd_auto_ref;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    dram_lp_seq #(
        .IDLE_W      (IDLE_W),
        .SR_EXIT_CYC (SR_X),
        .PD_EXIT_CYC (PD_X)
    ) u_dram_lp_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .sr_req       (sr_req),
        .q_rw_pending (q_rw_pending),
        .rw_inflight  (rw_inflight),
        .refresh_due  (refresh_due),
        .idle_limit   (idle_limit),
        .cmd_done     (cmd_done),
        .cke          (cke),
        .q_stall      (q_stall),
        .sr_ack       (sr_ack),
        .pd_ack       (pd_ack),
        .cmd_pre_all  (cmd_pre_all),
        .cmd_sr_enter (cmd_sr_enter),
        .cmd_auto_ref (cmd_auto_ref)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic pulse_done();
        cmd_done = 1'b1;
        step(1);
        cmd_done = 1'b0;
    endtask

    task automatic wait_pd(output int n);
        n = 0;
        for (int k = 0; k < 200; k++) begin
            step(1);
            n++;
            if (pd_ack) break;
        end
    endtask

    initial begin
        #400000;
        n_fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; sr_req = 1'b0; q_rw_pending = 1'b1; rw_inflight = 1'b0;
        refresh_due = 1'b0; cmd_done = 1'b0; idle_limit = '0;
        step(3);
        check("R1 cke in reset", cke, 1);
        check("R1 acks in reset", sr_ack | pd_ack, 0);
        rst_n = 1'b1;
        step(1);
        check("R1 cke", cke, 1);
        check("R1 acks", {sr_ack, pd_ack}, 0);
        check("R1 stall", q_stall, 0);
        check("R1 cmds", {cmd_pre_all, cmd_sr_enter, cmd_auto_ref}, 0);

        // R8: limit 0 never powers down
        q_rw_pending = 1'b0;
        step(20);
        check("R8 pd_ack with limit 0", pd_ack, 0);
        q_rw_pending = 1'b1;
        step(2);

        // R7 / R9: sweep idle limits, entry latency and wake
        for (int lim = 1; lim <= 8; lim++) begin
            idle_limit = IDLE_W'(lim);
            step(2);
            q_rw_pending = 1'b0;
            wait_pd(n);
            check("R7 entry latency", n, lim + 1);
            check("R9 cke low in pd", cke, 0);
            check("R9 stall in pd", q_stall, 1);
            q_rw_pending = 1'b1;
            step(1);
            check("R9 cke up on wake", cke, 1);
            check("R9 ack held", pd_ack, 1);
            step(PD_X - 1);
            check("R9 ack held to end", pd_ack, 1);
            step(1);
            check("R9 ack released", pd_ack, 0);
            check("R9 stall released", q_stall, 0);
        end

        // R7: a queued access clears the count part way
        idle_limit = 16'd6;
        q_rw_pending = 1'b0;
        step(4);
        q_rw_pending = 1'b1;
        step(1);
        q_rw_pending = 1'b0;
        wait_pd(n);
        check("R7 count cleared", n, 7);
        q_rw_pending = 1'b1;
        step(PD_X + 1);
        check("R7 back active", pd_ack, 0);

        // R10: refresh pending defers power-down
        idle_limit = 16'd2;
        refresh_due = 1'b1;
        step(1);
        refresh_due = 1'b0;
        q_rw_pending = 1'b0;
        step(1);
        check("R10 auto_ref requested", cmd_auto_ref, 1);
        step(10);
        check("R10 auto_ref held", cmd_auto_ref, 1);
        check("R10 no pd while refresh", pd_ack, 0);
        pulse_done();
        check("R10 auto_ref done", cmd_auto_ref, 0);
        wait_pd(n);
        check("R10 pd after refresh", n, 3);

        // R10: refresh strobe during power-down
        refresh_due = 1'b1;
        step(1);
        refresh_due = 1'b0;
        check("R10 wake on refresh", cke, 1);
        step(PD_X - 1);
        check("R10 pd ack held", pd_ack, 1);
        step(1);
        check("R10 pd ack dropped", pd_ack, 0);
        step(1);
        check("R10 auto_ref after wake", cmd_auto_ref, 1);
        q_rw_pending = 1'b1;
        pulse_done();

        // R11: self-refresh request during power-down
        q_rw_pending = 1'b0;
        wait_pd(n);
        check("R11 in pd", pd_ack, 1);
        sr_req = 1'b1;
        q_rw_pending = 1'b1;
        step(1);
        check("R11 cke up", cke, 1);
        check("R11 no sr_ack yet", sr_ack, 0);
        step(PD_X);
        check("R11 pd exit done", pd_ack, 0);
        step(1);
        check("R11 drain stall", q_stall, 1);
        check("R11 no pre yet", cmd_pre_all, 0);
        step(1);
        check("R11 pre-all", cmd_pre_all, 1);
        cmd_done = 1'b1;
        step(1);
        cmd_done = 1'b0;
        check("R3 entry cmd", cmd_sr_enter, 1);
        check("R3 cke low at entry", cke, 0);
        check("R3 no ack at entry", sr_ack, 0);
        step(1);
        check("R4 sr_ack", sr_ack, 1);
        check("R4 entry one cycle", cmd_sr_enter, 0);
        step(40);
        check("R4 ack held", sr_ack, 1);
        check("R4 cke held low", cke, 0);
        sr_req = 1'b0;
        step(1);
        check("R5 cke up", cke, 1);
        check("R5 ack still", sr_ack, 1);
        step(SR_X - 1);
        check("R5 ack to end", sr_ack, 1);
        check("R5 stall to end", q_stall, 1);
        step(1);
        check("R5 ack drop", sr_ack, 0);
        check("R5 stall drop", q_stall, 0);

        // R2 / R6: drain, and self-refresh beating a same-cycle refresh
        rw_inflight = 1'b1;
        sr_req = 1'b1;
        refresh_due = 1'b1;
        step(1);
        refresh_due = 1'b0;
        check("R2 stall", q_stall, 1);
        check("R6 no auto_ref", cmd_auto_ref, 0);
        step(3);
        check("R2 no pre while inflight", cmd_pre_all, 0);
        rw_inflight = 1'b0;
        step(1);
        check("R3 pre after drain", cmd_pre_all, 1);
        step(3);
        check("R3 pre held", cmd_pre_all, 1);
        pulse_done();
        check("R3 entry", cmd_sr_enter, 1);
        step(5);
        check("R6 in sr, no refresh", cmd_auto_ref, 0);
        check("R6 sr_ack", sr_ack, 1);
        sr_req = 1'b0;
        step(SR_X);
        check("R6 no refresh in exit", cmd_auto_ref, 0);
        step(1);
        check("R6 sr done", sr_ack, 0);
        step(1);
        check("R6 refresh after sr", cmd_auto_ref, 1);
        pulse_done();
        check("R6 refresh served", cmd_auto_ref, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule